// File: doc/BRIEF.md
# Fetch-Side Four-Entry Translation Buffer

This block translates instruction fetch addresses through four fully associative entries. Each entry stores a virtual page number, a physical page number, an address-space tag, a two-bit page size code, a valid flag, a shared flag, a user-execute permission flag and a cacheable flag. On every lookup cycle all four entries are compared with the fetch address in parallel. The block reports a single hit with its slot index, a miss, or a multiple hit. A hit that user mode may not execute is flagged as a protection fault. The translated physical address and the cacheable attribute are produced combinationally from the stored entries.

Replacement uses six pairwise-order bits. Each bit records which of two entries was used more recently. Every single hit refreshes these bits with a fixed clear/set pattern, and a fixed ordered set of pattern tests names the least recently used slot. When a refill entry arrives from a larger translation buffer, it is written into that slot and counts as a use of the slot. A flush input invalidates all four entries in one cycle.

Top module: `fetch_tlb4`

## Requirements
- R1: After reset no entry is valid, so every lookup misses. The order state reads 000000 and the victim index reads 3.
- R2: An entry matches only when its valid flag is set. It must also pass the tag test: its stored tag equals `curAsid`, or the entry is shared, or `asidCheckOff` is high. `hitIndex` gives the slot number (0 to 3) of a single matching entry.
- R3: Size code 00 selects 1 KB pages, 01 selects 4 KB, 10 selects 64 KB and 11 selects 1 MB. Address bits below the page size take no part in the compare. `physAddr` takes those low bits from the fetch address and the bits above them from the stored physical page number.
- R4: When `lookupValid` is high, exactly one of `tlbHit`, `tlbMiss` and `tlbMulti` is high. When `lookupValid` is low, all three are low.
- R5: Two or more matching entries raise `tlbMulti` instead of `tlbHit`, and leave the order state unchanged.
- R6: `protFault` is high exactly when `tlbHit` is high, `userMode` is 1 and the hit entry's user-execute flag is 0. Privileged fetches never fault.
- R7: A single hit updates the order state (bit 5 down to bit 0) as follows. Slot 0 clears bits 5..3. Slot 1 sets bit 5 and clears bits 2..1. Slot 2 sets bits 4 and 2 and clears bit 0. Slot 3 sets bits 3, 1 and 0.
- R8: The victim is the first slot whose test passes, checked in this order. Slot 0 when bits 5..3 are 111. Slot 1 when bit 5 is 0 and bits 2..1 are 11. Slot 2 when bits 4 and 2 are 0 and bit 0 is 1. Slot 3 when bits 3, 1 and 0 are all 0.
- R9: A refill (`fillValid`) writes all fields into the victim slot, sets its valid flag, and applies the R7 update for that slot. In that cycle the refill's update takes the place of any lookup update.
- R10: `flushAll` clears every valid flag at the clock edge and leaves the order state unchanged. A refill in the same cycle is discarded.
- R11: `cacheable` equals the hit entry's cacheable flag while `tlbHit` is high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | A fetch lookup is presented this cycle |
| lookupAddr | input | VA_W | Fetch virtual address |
| curAsid | input | ASID_W | Current address-space tag |
| asidCheckOff | input | 1 | Ignore address-space tags when comparing |
| userMode | input | 1 | 1 = user-mode fetch |
| flushAll | input | 1 | Invalidate every entry |
| fillValid | input | 1 | Write a refill entry into the victim slot |
| fillVpn | input | VA_W-10 | Refill virtual page number (address bits above 10) |
| fillPpn | input | PA_W-10 | Refill physical page number |
| fillAsid | input | ASID_W | Refill address-space tag |
| fillSize | input | 2 | Refill page size code |
| fillShared | input | 1 | Refill entry ignores the address-space tag |
| fillUserExec | input | 1 | Refill entry may be fetched in user mode |
| fillCache | input | 1 | Refill entry is cacheable |
| tlbHit | output | 1 | Exactly one entry matched |
| tlbMiss | output | 1 | No entry matched |
| tlbMulti | output | 1 | More than one entry matched |
| hitIndex | output | 2 | Slot of the single matching entry |
| physAddr | output | PA_W | Translated physical address |
| protFault | output | 1 | User-mode fetch from a privileged-only page |
| cacheable | output | 1 | Cacheable flag of the hit entry |
| lruState | output | 6 | Pairwise order state |
| victimIdx | output | 2 | Slot the next refill will replace |

## Verification
Some properties are checked by assertions on every cycle. The three result flags are mutually exclusive and are gated by the lookup strobe. A fault always implies a user-mode hit. A flush empties the buffer and leaves the order state as it was, and so does a multiple hit. After a single hit the victim is never the slot just used. A refill always moves the victim pointer elsewhere. Other behaviour can only be shown by the bench's scenarios, which it checks against a reference model. These are the exact physical address for each page size, the tag and shared-flag matching, the bit patterns of every order update, the victim sequence, and the outcome when a refill meets a flush or a hit in the same cycle.

// File: rtl/ftlb_pkg.sv
package ftlb_pkg;

  localparam int TLB_ENTRIES = 4;
  localparam int IDX_W       = 2;
  localparam int LRU_W       = 6;
  localparam int CNT_W       = $clog2(TLB_ENTRIES + 1);
  localparam int OFF_W       = 10;

  typedef enum logic [1:0] {
    PG_1K  = 2'b00,
    PG_4K  = 2'b01,
    PG_64K = 2'b10,
    PG_1M  = 2'b11
  } pageSize_t;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             flush;
  } ftlbStrobe_t;

  function automatic int unsigned pageShift(input logic [1:0] code);
    case (pageSize_t'(code))
      PG_1K:   pageShift = 10;
      PG_4K:   pageShift = 12;
      PG_64K:  pageShift = 16;
      default: pageShift = 20;
    endcase
  endfunction

  // Pairwise order refresh for a use of slot idx.
  function automatic logic [LRU_W-1:0] orderTouch(input logic [LRU_W-1:0] s,
                                                  input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    orderTouch = s & 6'b000111;
      2'd1:    orderTouch = (s & 6'b111001) | 6'b100000;
      2'd2:    orderTouch = (s & 6'b111110) | 6'b010100;
      default: orderTouch = s | 6'b001011;
    endcase
  endfunction

  // Ordered pattern tests; the last branch covers states no use sequence reaches.
  function automatic logic [IDX_W-1:0] orderVictim(input logic [LRU_W-1:0] s);
    if (s[5:3] == 3'b111)                  orderVictim = 2'd0;
    else if (!s[5] && s[2:1] == 2'b11)     orderVictim = 2'd1;
    else if (!s[4] && !s[2] && s[0])       orderVictim = 2'd2;
    else if (!s[3] && !s[1] && !s[0])      orderVictim = 2'd3;
    else                                   orderVictim = 2'd0;
  endfunction

endpackage

// File: rtl/ftlb_datapath.sv
module ftlb_datapath
  import ftlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 29,
  parameter int ASID_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ftlbStrobe_t            strobe,
  input  logic [VA_W-OFF_W-1:0]  fillVpn,
  input  logic [PA_W-OFF_W-1:0]  fillPpn,
  input  logic [ASID_W-1:0]      fillAsid,
  input  logic [1:0]             fillSize,
  input  logic                   fillShared,
  input  logic                   fillUserExec,
  input  logic                   fillCache,
  input  logic [VA_W-1:0]        lookupAddr,
  input  logic [ASID_W-1:0]      curAsid,
  input  logic                   asidCheckOff,
  output logic [TLB_ENTRIES-1:0] matchVec,
  output logic [PA_W-1:0]        selPhys,
  output logic                   selUserExec,
  output logic                   selCache
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [TLB_ENTRIES-1:0] validQ;
  logic [TLB_ENTRIES-1:0] sharedQ;
  logic [TLB_ENTRIES-1:0] userExecQ;
  logic [TLB_ENTRIES-1:0] cacheQ;
  logic [VPN_W-1:0]       vpnQ  [TLB_ENTRIES];
  logic [PPN_W-1:0]       ppnQ  [TLB_ENTRIES];
  logic [ASID_W-1:0]      asidQ [TLB_ENTRIES];
  logic [1:0]             sizeQ [TLB_ENTRIES];
  logic [PA_W-1:0]        physArr [TLB_ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ    <= '0;
      sharedQ   <= '0;
      userExecQ <= '0;
      cacheQ    <= '0;
      for (int i = 0; i < TLB_ENTRIES; i++) begin
        vpnQ[i]  <= '0;
        ppnQ[i]  <= '0;
        asidQ[i] <= '0;
        sizeQ[i] <= '0;
      end
    end else if (strobe.flush) begin
      validQ <= '0;
    end else if (strobe.wrEn) begin
      validQ[strobe.wrIdx]    <= 1'b1;
      sharedQ[strobe.wrIdx]   <= fillShared;
      userExecQ[strobe.wrIdx] <= fillUserExec;
      cacheQ[strobe.wrIdx]    <= fillCache;
      vpnQ[strobe.wrIdx]      <= fillVpn;
      ppnQ[strobe.wrIdx]      <= fillPpn;
      asidQ[strobe.wrIdx]     <= fillAsid;
      sizeQ[strobe.wrIdx]     <= fillSize;
    end
  end

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : gSlot
    logic [VPN_W-1:0] cmpMask;
    logic [PA_W-1:0]  offMask;
    logic             tagOk;
    logic             pageEq;

    always_comb begin
      cmpMask = {VPN_W{1'b1}} << (pageShift(sizeQ[g]) - OFF_W);
      offMask = ~({PA_W{1'b1}} << pageShift(sizeQ[g]));
      tagOk   = sharedQ[g] | asidCheckOff | (asidQ[g] == curAsid);
      pageEq  = ((lookupAddr[VA_W-1:OFF_W] ^ vpnQ[g]) & cmpMask) == '0;
    end

    assign matchVec[g] = validQ[g] & tagOk & pageEq;
    assign physArr[g]  = ({ppnQ[g], {OFF_W{1'b0}}} & ~offMask) |
                         (lookupAddr[PA_W-1:0] & offMask);
  end

  // One-hot OR mux; meaningful only when a single slot matches.
  always_comb begin
    selPhys     = '0;
    selUserExec = 1'b0;
    selCache    = 1'b0;
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      if (matchVec[i]) begin
        selPhys     = selPhys | physArr[i];
        selUserExec = selUserExec | userExecQ[i];
        selCache    = selCache | cacheQ[i];
      end
    end
  end

endmodule

// File: rtl/ftlb_control.sv
module ftlb_control
  import ftlb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lookupValid,
  input  logic [TLB_ENTRIES-1:0] matchVec,
  input  logic                   fillValid,
  input  logic                   flushAll,
  output ftlbStrobe_t            strobe,
  output logic [IDX_W-1:0]       hitIdx,
  output logic                   hitOne,
  output logic                   noHit,
  output logic                   manyHit,
  output logic [LRU_W-1:0]       lruState,
  output logic [IDX_W-1:0]       victimIdx
);

  logic [CNT_W-1:0] matchCnt;
  logic [LRU_W-1:0] lruNext;
  logic             fillTakes;

  always_comb begin
    hitIdx   = '0;
    matchCnt = '0;
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitIdx   = IDX_W'(i);
        matchCnt = matchCnt + CNT_W'(1);
      end
    end
  end

  assign hitOne    = (matchCnt == CNT_W'(1));
  assign noHit     = (matchCnt == '0);
  assign manyHit   = (matchCnt > CNT_W'(1));
  assign victimIdx = orderVictim(lruState);
  assign fillTakes = fillValid & ~flushAll;

  assign strobe.wrEn  = fillTakes;
  assign strobe.wrIdx = victimIdx;
  assign strobe.flush = flushAll;

  always_comb begin
    lruNext = lruState;
    if (fillTakes)
      lruNext = orderTouch(lruState, victimIdx);
    else if (lookupValid && hitOne)
      lruNext = orderTouch(lruState, hitIdx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lruState <= '0;
    else        lruState <= lruNext;
  end

endmodule

// File: rtl/fetch_tlb4.sv
module fetch_tlb4
  import ftlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 29,
  parameter int ASID_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lookupValid,
  input  logic [VA_W-1:0]       lookupAddr,
  input  logic [ASID_W-1:0]     curAsid,
  input  logic                  asidCheckOff,
  input  logic                  userMode,
  input  logic                  flushAll,
  input  logic                  fillValid,
  input  logic [VA_W-11:0]      fillVpn,
  input  logic [PA_W-11:0]      fillPpn,
  input  logic [ASID_W-1:0]     fillAsid,
  input  logic [1:0]            fillSize,
  input  logic                  fillShared,
  input  logic                  fillUserExec,
  input  logic                  fillCache,
  output logic                  tlbHit,
  output logic                  tlbMiss,
  output logic                  tlbMulti,
  output logic [1:0]            hitIndex,
  output logic [PA_W-1:0]       physAddr,
  output logic                  protFault,
  output logic                  cacheable,
  output logic [5:0]            lruState,
  output logic [1:0]            victimIdx
);

  ftlbStrobe_t            strobe;
  logic [TLB_ENTRIES-1:0] matchVec;
  logic [PA_W-1:0]        selPhys;
  logic                   selUserExec;
  logic                   selCache;
  logic                   hitOne;
  logic                   noHit;
  logic                   manyHit;

  ftlb_datapath #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) uDp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .fillVpn      (fillVpn),
    .fillPpn      (fillPpn),
    .fillAsid     (fillAsid),
    .fillSize     (fillSize),
    .fillShared   (fillShared),
    .fillUserExec (fillUserExec),
    .fillCache    (fillCache),
    .lookupAddr   (lookupAddr),
    .curAsid      (curAsid),
    .asidCheckOff (asidCheckOff),
    .matchVec     (matchVec),
    .selPhys      (selPhys),
    .selUserExec  (selUserExec),
    .selCache     (selCache)
  );

  ftlb_control uCtl (
    .clk         (clk),
    .rst_n       (rst_n),
    .lookupValid (lookupValid),
    .matchVec    (matchVec),
    .fillValid   (fillValid),
    .flushAll    (flushAll),
    .strobe      (strobe),
    .hitIdx      (hitIndex),
    .hitOne      (hitOne),
    .noHit       (noHit),
    .manyHit     (manyHit),
    .lruState    (lruState),
    .victimIdx   (victimIdx)
  );

  assign tlbHit    = lookupValid & hitOne;
  assign tlbMiss   = lookupValid & noHit;
  assign tlbMulti  = lookupValid & manyHit;
  assign physAddr  = selPhys;
  assign protFault = tlbHit & userMode & ~selUserExec;
  assign cacheable = tlbHit & selCache;

endmodule

// File: rtl/fetch_tlb4_checker.sv
module fetch_tlb4_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       lookupValid,
  input logic       userMode,
  input logic       flushAll,
  input logic       fillValid,
  input logic       tlbHit,
  input logic       tlbMiss,
  input logic       tlbMulti,
  input logic [1:0] hitIndex,
  input logic       protFault,
  input logic [5:0] lruState,
  input logic [1:0] victimIdx
);

  a_r4_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |-> ($countones({tlbHit, tlbMiss, tlbMulti}) == 1));

  a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |-> !(tlbHit || tlbMiss || tlbMulti));

  a_r6_fault_user_hit: assert property (@(posedge clk) disable iff (!rst_n)
    protFault |-> (tlbHit && userMode));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flushAll |=> !(tlbHit || tlbMulti));

  a_r10_flush_keeps_order: assert property (@(posedge clk) disable iff (!rst_n)
    (flushAll && !tlbHit) |=> $stable(lruState));

  a_r5_multi_keeps_order: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbMulti && !(fillValid && !flushAll)) |=> $stable(lruState));

  a_r7_slot0_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbHit && hitIndex == 2'd0 && !(fillValid && !flushAll)) |=> (lruState[5:3] == 3'b000));

  a_r8_victim_not_recent: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbHit && !(fillValid && !flushAll)) |=> (victimIdx != $past(hitIndex)));

  a_r9_fill_moves_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (fillValid && !flushAll) |=> (victimIdx != $past(victimIdx)));

endmodule

bind fetch_tlb4 fetch_tlb4_checker chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lookupValid (lookupValid),
  .userMode    (userMode),
  .flushAll    (flushAll),
  .fillValid   (fillValid),
  .tlbHit      (tlbHit),
  .tlbMiss     (tlbMiss),
  .tlbMulti    (tlbMulti),
  .hitIndex    (hitIndex),
  .protFault   (protFault),
  .lruState    (lruState),
  .victimIdx   (victimIdx)
);

// File: tb/fetch_tlb4_test.sv
`timescale 1ns/1ps
module fetch_tlb4_test;

  localparam int VA_W = 32;
  localparam int PA_W = 29;
  localparam int AW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lv = 0, aoff = 0, um = 0, fl = 0, fv = 0, fSh = 0, fUx = 0, fC = 0;
  logic [VA_W-1:0]  la = '0;
  logic [AW-1:0]    asid = '0, fAsid = '0;
  logic [VA_W-11:0] fVpn = '0;
  logic [PA_W-11:0] fPpn = '0;
  logic [1:0]       fSz = '0;

  logic tlbHit, tlbMiss, tlbMulti, protFault, cacheable;
  logic [1:0] hitIndex, victimIdx;
  logic [PA_W-1:0] physAddr;
  logic [5:0] lruState;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference model
  logic             mV  [4];
  logic [VA_W-11:0] mVpn[4];
  logic [PA_W-11:0] mPpn[4];
  logic [AW-1:0]    mAs [4];
  logic [1:0]       mSz [4];
  logic             mSh [4], mUx[4], mC[4];
  logic [5:0]       mLru;
  logic [VA_W-11:0] pool [8];

  always #2.5 clk = ~clk;

  fetch_tlb4 #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .lookupValid(lv), .lookupAddr(la), .curAsid(asid),
    .asidCheckOff(aoff), .userMode(um), .flushAll(fl), .fillValid(fv),
    .fillVpn(fVpn), .fillPpn(fPpn), .fillAsid(fAsid), .fillSize(fSz),
    .fillShared(fSh), .fillUserExec(fUx), .fillCache(fC),
    .tlbHit(tlbHit), .tlbMiss(tlbMiss), .tlbMulti(tlbMulti), .hitIndex(hitIndex),
    .physAddr(physAddr), .protFault(protFault), .cacheable(cacheable),
    .lruState(lruState), .victimIdx(victimIdx)
  );

  function automatic logic [5:0] touch(logic [5:0] s, logic [1:0] i);
    case (i)  // R7 patterns
      2'd0: return s & 6'b000111;
      2'd1: return {1'b1, s[4:3], 2'b00, s[0]};
      2'd2: return {s[5], 1'b1, s[3], 1'b1, s[1], 1'b0};
      default: return {s[5:4], 1'b1, s[2], 2'b11};
    endcase
  endfunction

  function automatic logic [1:0] pick(logic [5:0] s);
    if (s[5] && s[4] && s[3]) return 2'd0;  // R8 ordered tests
    if (!s[5] && s[2] && s[1]) return 2'd1;
    if (!s[4] && !s[2] && s[0]) return 2'd2;
    return 2'd3;
  endfunction

  function automatic int sh(logic [1:0] c);
    return (c == 0) ? 10 : (c == 1) ? 12 : (c == 2) ? 16 : 20;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Called 1 ns after inputs settle; compares, then advances the model past the edge.
  task automatic evalStep();
    int cnt = 0;
    int idx = 0;
    logic [PA_W-1:0] ep;
    logic [PA_W-1:0] om;
    logic [1:0] vic;
    #1;
    for (int i = 0; i < 4; i++) begin
      logic [VA_W-11:0] m;
      m = {(VA_W-10){1'b1}} << (sh(mSz[i]) - 10);
      if (mV[i] && (mSh[i] || aoff || mAs[i] == asid) &&
          (((la[VA_W-1:10] ^ mVpn[i]) & m) == '0)) begin
        cnt++;
        idx = i;
      end
    end
    chk((cnt > 1) ? "R5" : "R4", {tlbHit, tlbMiss, tlbMulti},
        {lv && cnt == 1, lv && cnt == 0, lv && cnt > 1});
    if (lv && cnt == 1) begin
      om = ~({PA_W{1'b1}} << sh(mSz[idx]));
      ep = ({mPpn[idx], 10'b0} & ~om) | (la[PA_W-1:0] & om);
      chk("R2", 32'(hitIndex), 32'(idx));
      chk("R3", 32'(physAddr), 32'(ep));
      chk("R6", 32'(protFault), 32'(um && !mUx[idx]));
      chk("R11", 32'(cacheable), 32'(mC[idx]));
    end else begin
      chk("R6", 32'(protFault), 0);
      chk("R11", 32'(cacheable), 0);
    end
    chk("R7", 32'(lruState), 32'(mLru));
    vic = pick(mLru);
    chk("R8", 32'(victimIdx), 32'(vic));
    if (fl) begin
      for (int i = 0; i < 4; i++) mV[i] = 0;
    end else if (fv) begin
      mV[vic] = 1; mVpn[vic] = fVpn; mPpn[vic] = fPpn; mAs[vic] = fAsid;
      mSz[vic] = fSz; mSh[vic] = fSh; mUx[vic] = fUx; mC[vic] = fC;
      mLru = touch(mLru, vic);
    end
    if (!(fv && !fl) && lv && cnt == 1) mLru = touch(mLru, 2'(idx));
    @(negedge clk);
  endtask

  task automatic idle();
    lv = 0; fl = 0; fv = 0; aoff = 0; um = 0;
  endtask

  task automatic fill(logic [VA_W-11:0] v, logic [PA_W-11:0] p, logic [7:0] a,
                      logic [1:0] s, logic shr, logic ux, logic c);
    fv = 1; fVpn = v; fPpn = p; fAsid = a; fSz = s; fSh = shr; fUx = ux; fC = c;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mV[i] = 0; mVpn[i] = '0; mPpn[i] = '0; mAs[i] = '0; mSz[i] = '0;
      mSh[i] = 0; mUx[i] = 0; mC[i] = 0;
    end
    mLru = '0;
    void'($urandom(32'h1f3c5a7));
    for (int i = 0; i < 8; i++) pool[i] = (VA_W-10)'($urandom);
    pool[1] = pool[0] ^ 22'h1;     // same 4 KB page as pool[0]
    pool[2] = pool[0] ^ 22'h200;   // same 1 MB page as pool[0]
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    lv = 1; la = 32'h0040_1234; asid = 8'd1;
    #1;
    chk("R1", {tlbHit, tlbMiss, tlbMulti}, 3'b010);
    chk("R1", 32'(lruState), 0);
    chk("R1", 32'(victimIdx), 3);
    evalStep();

    // R9: four refills land in slots 3,2,1,0
    idle(); fill(22'h00100, 19'h00a1, 8'd5, 2'd0, 0, 1, 1); evalStep();
    idle(); fill(22'h00200, 19'h00b2, 8'd5, 2'd1, 1, 0, 0); evalStep();
    idle(); fill(22'h04000, 19'h0c33, 8'd6, 2'd2, 0, 1, 0); evalStep();
    idle(); fill(22'h10000, 19'h1d44, 8'd7, 2'd3, 0, 0, 1); evalStep();
    chk("R9", 32'(victimIdx), 3);

    // R2: tag mismatch, tag override, shared entry
    idle(); lv = 1; asid = 8'd6; la = {22'h00100, 10'h3ff}; evalStep();
    idle(); lv = 1; asid = 8'd6; aoff = 1; la = {22'h00100, 10'h155}; evalStep();
    idle(); lv = 1; asid = 8'd9; la = {22'h00203, 10'h001}; evalStep();
    // R3/R6: large pages, user fetch from privileged page
    idle(); lv = 1; asid = 8'd7; um = 1; la = {22'h103ff, 10'h2aa}; evalStep();
    idle(); lv = 1; asid = 8'd6; um = 1; la = {22'h0403f, 10'h0f0}; evalStep();
    // R9: refill and hit in the same cycle
    idle(); lv = 1; asid = 8'd6; la = {22'h04000, 10'h0}; fill(22'h20000, 19'h0001, 8'd6, 2'd0, 0, 1, 0); evalStep();
    // R5: overlapping entries
    idle(); fill(22'h04001, 19'h0777, 8'd6, 2'd0, 0, 1, 0); evalStep();
    idle(); lv = 1; asid = 8'd6; la = {22'h04001, 10'h010}; evalStep();
    // R10: flush with a simultaneous refill, then lookups miss
    idle(); fl = 1; fill(22'h00300, 19'h0003, 8'd6, 2'd0, 1, 1, 1); evalStep();
    idle(); lv = 1; asid = 8'd6; la = {22'h00300, 10'h0}; evalStep();
    chk("R10", 32'(tlbMiss), 1);
    idle(); lv = 1; asid = 8'd6; la = {22'h04000, 10'h0}; evalStep();

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      r = int'($urandom % 100);
      if (r < 30) fill(pool[$urandom % 8], 19'($urandom), 8'($urandom % 3),
                       2'($urandom), ($urandom % 4) == 0, 1'($urandom), 1'($urandom));
      lv   = ($urandom % 4) != 0;
      la   = {pool[$urandom % 8] ^ 22'($urandom % 4), 10'($urandom)};
      if (($urandom % 8) == 0) la = $urandom;
      asid = 8'($urandom % 3);
      aoff = ($urandom % 10) == 0;
      um   = 1'($urandom);
      fl   = ($urandom % 80) == 0;
      evalStep();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule